// File: doc/BRIEF.md
# Split-Half 32-Pin GPIO Controller

This block drives and samples 32 general-purpose pins through a register file in which every 32-bit quantity is reached as two 16-bit halves at separate offsets, so a 16-bit host can reach every bit. It holds the pin output levels, a per-pin drive enable, the sampled pin levels, one mask that arms rising transitions, a second mask that arms falling transitions, and a sticky event status that feeds a single interrupt line.

Pin inputs pass through a two-flop synchroniser. The synchronised level is then compared with the last sampled level. A pin whose level has changed, and whose matching edge mask bit is set, latches its status bit. Software clears status bits by writing ones to them. Three side outputs come straight from the register contents: a 3-bit display brightness code, and the data and clock lines of a bit-banged I2C bus taken from two upper output bits.

Top module: `gpio_split32`

## Requirements
- R1: After a synchronous reset, both halves of the input register read 0xFFFF. Output, drive enable, both edge masks and status read 0x0000. `irq`, `bright_code`, `i2c_sda` and `i2c_scl` are all 0.
- R2: The register offsets (low half / high half) are: drive enable 0x008/0x508, output 0x00C/0x50C, input 0x010/0x510, falling mask 0x014/0x514, rising mask 0x018/0x518, status 0x020/0x520. A write to a low offset replaces bits 15:0 and a write to a high offset replaces bits 31:16. The other half does not change. A read returns the addressed 16 bits right-aligned in `bus_rdata`. `gpio_out` and `gpio_oe` show the full registers.
- R3: When a pin goes from 0 to 1 and its rising-mask bit is set, its status bit becomes 1. The change is seen in status and `irq` on the third rising clock edge after the pin changes (two synchroniser flops, then the compare).
- R4: When a pin goes from 1 to 0 and its falling-mask bit is set, its status bit becomes 1, with the same three-edge latency.
- R5: A transition whose matching mask bit is clear sets no status bit. A pin that does not change level sets nothing, whatever its mask bits are.
- R6: `irq` is 1 exactly when any status bit is 1. Writing a status half clears the bits written as 1 and leaves the bits written as 0.
- R7: If a status clear and a new event hit the same bit in the same clock cycle, the bit ends up set.
- R8: `i2c_sda` follows output bit 29 and `i2c_scl` follows output bit 30. Both change only through writes to the high output half.
- R9: `bright_code` is the bitwise OR of output bits 18:16 and drive-enable bits 18:16 (bits 2:0 of the high drive-enable half). Those drive-enable bits read back through 0x508.
- R10: Writes to offsets not listed in R2 change nothing, and reads from them return 0.
- R11: The input register reads the synchronised pin levels three edges after a change, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 12 | Byte offset of the register half |
| bus_wdata | input | 16 | Write data for one half |
| bus_rdata | output | 16 | Read data of the addressed half, combinational |
| pin_in | input | 32 | Asynchronous pin levels |
| gpio_out | output | 32 | Output register |
| gpio_oe | output | 32 | Drive enable register |
| irq | output | 1 | OR of all status bits |
| bright_code | output | 3 | Display brightness code |
| i2c_sda | output | 1 | Bit-banged I2C data line |
| i2c_scl | output | 1 | Bit-banged I2C clock line |

## Verification
The status register has two writers. Software clears bits by writing ones, and the edge detector sets them, and both can hit the same bit on the same clock edge. The bench arms a rising mask and moves the pin. Exactly two edges later it issues a clear covering that bit and also a second bit that was already set. After the edge, the armed bit must be set and the second bit must be clear. Random pin patterns against random masks and random clears also check the status model after each step.

// File: rtl/gpio_split_pkg.sv
package gpio_split_pkg;

    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_OE   = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_OUT  = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_IN   = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_FALL = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_RISE = 12'h018;
    localparam logic [ADDR_W-1:0] OFS_STAT = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_STEP = 12'h500;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_OE,
        SEL_OUT,
        SEL_IN,
        SEL_FALL,
        SEL_RISE,
        SEL_STAT
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e sel;
        logic     upper;
    } reg_hit_t;

    function automatic reg_sel_e base_sel(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_OE:   s = SEL_OE;
            OFS_OUT:  s = SEL_OUT;
            OFS_IN:   s = SEL_IN;
            OFS_FALL: s = SEL_FALL;
            OFS_RISE: s = SEL_RISE;
            OFS_STAT: s = SEL_STAT;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic reg_hit_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_hit_t h;
        if (a >= OFS_STEP) begin
            h.sel   = base_sel(a - OFS_STEP);
            h.upper = 1'b1;
        end else begin
            h.sel   = base_sel(a);
            h.upper = 1'b0;
        end
        return h;
    endfunction

endpackage

// File: rtl/gpio_half_reg.sv
module gpio_half_reg #(
    parameter int HALF_W = 16,
    parameter logic [2*HALF_W-1:0] RST_VAL = '0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic [HALF_W-1:0]     wdata,
    output logic [2*HALF_W-1:0]   q
);
    localparam int NHALF = 2;

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        logic wr_this;
        assign wr_this = (h == 0) ? wr_lo : wr_hi;
        always_ff @(posedge clk) begin
            if (rst) begin
                q[h*HALF_W +: HALF_W] <= RST_VAL[h*HALF_W +: HALF_W];
            end else if (wr_this) begin
                q[h*HALF_W +: HALF_W] <= wdata;
            end
        end
    end
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pins,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    output logic [W-1:0] level,
    output logic [W-1:0] events
);
    logic [W-1:0] sync_a;
    logic [W-1:0] sync_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_a <= '1;
            sync_b <= '1;
            level  <= '1;
        end else begin
            sync_a <= pins;
            sync_b <= sync_a;
            level  <= sync_b;
        end
    end

    always_comb begin
        events = (sync_b & ~level & rise_en) | (~sync_b & level & fall_en);
    end
endmodule

// File: rtl/gpio_status.sv
module gpio_status #(
    parameter int HALF_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [2*HALF_W-1:0]   set_vec,
    input  logic                  clr_lo,
    input  logic                  clr_hi,
    input  logic [HALF_W-1:0]     wdata,
    output logic [2*HALF_W-1:0]   status,
    output logic                  irq
);
    localparam int W = 2 * HALF_W;
    logic [W-1:0] clr_mask;

    for (genvar h = 0; h < 2; h++) begin : g_clr
        logic hit;
        assign hit = (h == 0) ? clr_lo : clr_hi;
        assign clr_mask[h*HALF_W +: HALF_W] = hit ? wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
        end else begin
            status <= (status & ~clr_mask) | set_vec;
        end
    end

    assign irq = |status;
endmodule

// File: rtl/gpio_split32.sv
module gpio_split32
    import gpio_split_pkg::*;
#(
    parameter int HALF_W     = 16,
    parameter int BRIGHT_W   = 3,
    parameter int BRIGHT_LSB = 16,
    parameter int SDA_BIT    = 29,
    parameter int SCL_BIT    = 30
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic [11:0]          bus_addr,
    input  logic [15:0]          bus_wdata,
    output logic [15:0]          bus_rdata,
    input  logic [31:0]          pin_in,
    output logic [31:0]          gpio_out,
    output logic [31:0]          gpio_oe,
    output logic                 irq,
    output logic [2:0]           bright_code,
    output logic                 i2c_sda,
    output logic                 i2c_scl
);
    localparam int W = 2 * HALF_W;

    reg_hit_t     hit;
    logic [W-1:0] rise_en;
    logic [W-1:0] fall_en;
    logic [W-1:0] in_level;
    logic [W-1:0] events;
    logic [W-1:0] status;

    assign hit = decode_addr(bus_addr);

    function automatic logic wr_of(input reg_hit_t h, input reg_sel_e s,
                                   input logic up, input logic we);
        return we && (h.sel == s) && (h.upper == up);
    endfunction

    gpio_half_reg #(.HALF_W(HALF_W)) u_oe (
        .clk(clk), .rst(rst),
        .wr_lo(wr_of(hit, SEL_OE, 1'b0, bus_wr)),
        .wr_hi(wr_of(hit, SEL_OE, 1'b1, bus_wr)),
        .wdata(bus_wdata), .q(gpio_oe)
    );

    gpio_half_reg #(.HALF_W(HALF_W)) u_out (
        .clk(clk), .rst(rst),
        .wr_lo(wr_of(hit, SEL_OUT, 1'b0, bus_wr)),
        .wr_hi(wr_of(hit, SEL_OUT, 1'b1, bus_wr)),
        .wdata(bus_wdata), .q(gpio_out)
    );

    gpio_half_reg #(.HALF_W(HALF_W)) u_fall (
        .clk(clk), .rst(rst),
        .wr_lo(wr_of(hit, SEL_FALL, 1'b0, bus_wr)),
        .wr_hi(wr_of(hit, SEL_FALL, 1'b1, bus_wr)),
        .wdata(bus_wdata), .q(fall_en)
    );

    gpio_half_reg #(.HALF_W(HALF_W)) u_rise (
        .clk(clk), .rst(rst),
        .wr_lo(wr_of(hit, SEL_RISE, 1'b0, bus_wr)),
        .wr_hi(wr_of(hit, SEL_RISE, 1'b1, bus_wr)),
        .wdata(bus_wdata), .q(rise_en)
    );

    gpio_edge_det #(.W(W)) u_edge (
        .clk(clk), .rst(rst), .pins(pin_in),
        .rise_en(rise_en), .fall_en(fall_en),
        .level(in_level), .events(events)
    );

    gpio_status #(.HALF_W(HALF_W)) u_stat (
        .clk(clk), .rst(rst), .set_vec(events),
        .clr_lo(wr_of(hit, SEL_STAT, 1'b0, bus_wr)),
        .clr_hi(wr_of(hit, SEL_STAT, 1'b1, bus_wr)),
        .wdata(bus_wdata), .status(status), .irq(irq)
    );

    function automatic logic [HALF_W-1:0] pick(input logic [W-1:0] v, input logic up);
        return up ? v[HALF_W +: HALF_W] : v[HALF_W-1:0];
    endfunction

    always_comb begin
        case (hit.sel)
            SEL_OE:   bus_rdata = pick(gpio_oe,  hit.upper);
            SEL_OUT:  bus_rdata = pick(gpio_out, hit.upper);
            SEL_IN:   bus_rdata = pick(in_level, hit.upper);
            SEL_FALL: bus_rdata = pick(fall_en,  hit.upper);
            SEL_RISE: bus_rdata = pick(rise_en,  hit.upper);
            SEL_STAT: bus_rdata = pick(status,   hit.upper);
            default:  bus_rdata = '0;
        endcase
    end

    assign bright_code = gpio_out[BRIGHT_LSB +: BRIGHT_W] | gpio_oe[HALF_W +: BRIGHT_W];
    assign i2c_sda     = gpio_out[SDA_BIT];
    assign i2c_scl     = gpio_out[SCL_BIT];
endmodule

// File: rtl/gpio_split32_chk.sv
module gpio_split32_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_wr,
    input logic [11:0] bus_addr,
    input logic [31:0] gpio_out,
    input logic        irq,
    input logic [2:0]  bright_code,
    input logic        i2c_sda,
    input logic        i2c_scl,
    input logic [31:0] rise_en,
    input logic [31:0] fall_en
);
    logic stat_wr;
    assign stat_wr = bus_wr && (bus_addr == 12'h020 || bus_addr == 12'h520);

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq && gpio_out == 32'h0)); // R1
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(gpio_out)); // R2
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq && !stat_wr) |=> irq); // R6
    AST_NO_ARMED_EDGE: assert property (@(posedge clk) disable iff (rst)
        (!irq && rise_en == 32'h0 && fall_en == 32'h0) |=> !irq); // R5
    AST_I2C_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable({i2c_sda, i2c_scl})); // R8
    AST_BRIGHT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(bright_code)); // R9
endmodule

bind gpio_split32 gpio_split32_chk u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .gpio_out(gpio_out), .irq(irq), .bright_code(bright_code),
    .i2c_sda(i2c_sda), .i2c_scl(i2c_scl),
    .rise_en(rise_en), .fall_en(fall_en)
);

// File: tb/gpio_split32_test.sv
module gpio_split32_test;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [31:0] pin_in = '1;
    logic [31:0] gpio_out, gpio_oe;
    logic        irq, i2c_sda, i2c_scl;
    logic [2:0]  bright_code;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic [31:0] m_oe = '0, m_out = '0, m_fall = '0, m_rise = '0, m_stat = '0, m_in = '1;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_split32 uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .gpio_out(gpio_out), .gpio_oe(gpio_oe), .irq(irq),
        .bright_code(bright_code), .i2c_sda(i2c_sda), .i2c_scl(i2c_scl)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic chk_reg(input string req, input logic [11:0] lo, input logic [31:0] exp);
        logic [15:0] d;
        rd(lo, d);
        check(req, {16'h0, d}, {16'h0, exp[15:0]});
        rd(lo + 12'h500, d);
        check(req, {16'h0, d}, {16'h0, exp[31:16]});
    endtask

    function automatic logic [2:0] exp_bright();
        return m_out[18:16] | m_oe[18:16];
    endfunction

    task automatic chk_side(input string req);
        check(req, {29'h0, bright_code}, {29'h0, exp_bright()});
        check(req, {30'h0, i2c_sda, i2c_scl}, {30'h0, m_out[29], m_out[30]});
    endtask

    task automatic apply_pins(input logic [31:0] p);
        m_stat |= (p & ~m_in & m_rise) | (~p & m_in & m_fall);
        m_in = p;
        pin_in = p;
        repeat (3) @(negedge clk);
    endtask

    task automatic clr_stat(input logic [31:0] c);
        wr(12'h020, c[15:0]);
        wr(12'h520, c[31:16]);
        m_stat &= ~c;
    endtask

    function automatic logic [11:0] base_of(input int i);
        case (i)
            0: return 12'h008;
            1: return 12'h00C;
            2: return 12'h014;
            default: return 12'h018;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk_reg("R1 oe", 12'h008, 32'h0);
        chk_reg("R1 out", 12'h00C, 32'h0);
        chk_reg("R1 in", 12'h010, 32'hFFFF_FFFF);
        chk_reg("R1 fall", 12'h014, 32'h0);
        chk_reg("R1 rise", 12'h018, 32'h0);
        chk_reg("R1 stat", 12'h020, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        chk_side("R1 side");

        // R2 half writes leave the other half alone
        wr(12'h00C, 16'h1234); m_out[15:0] = 16'h1234;
        wr(12'h50C, 16'h0000); m_out[31:16] = 16'h0000;
        chk_reg("R2 out halves", 12'h00C, m_out);
        check("R2 gpio_out", gpio_out, m_out);

        // R9 brightness: out bits 18:16 OR oe hi bits 2:0
        wr(12'h508, 16'h0005); m_oe[31:16] = 16'h0005;
        check("R9 bright oe only", {29'h0, bright_code}, 32'd5);
        wr(12'h50C, 16'h0002); m_out[31:16] = 16'h0002;
        check("R9 bright or", {29'h0, bright_code}, 32'd7);
        rd(12'h508, d);
        check("R9 oe readback", {16'h0, d}, 32'h5);
        check("R2 gpio_oe", gpio_oe, m_oe);

        // R8 I2C lines: sda = bit 29 (hi bit 13), scl = bit 30 (hi bit 14)
        wr(12'h50C, 16'h2000); m_out[31:16] = 16'h2000;
        check("R8 sda only", {30'h0, i2c_sda, i2c_scl}, 32'b10);
        wr(12'h50C, 16'h4000); m_out[31:16] = 16'h4000;
        check("R8 scl only", {30'h0, i2c_sda, i2c_scl}, 32'b01);
        wr(12'h00C, 16'hFFFF); m_out[15:0] = 16'hFFFF;
        check("R8 low write no effect", {30'h0, i2c_sda, i2c_scl}, 32'b01);

        // R10 unmapped offsets
        wr(12'h024, 16'hABCD);
        wr(12'h000, 16'hABCD);
        wr(12'h50A, 16'hABCD);
        rd(12'h024, d);
        check("R10 read zero", {16'h0, d}, 32'h0);
        rd(12'h700, d);
        check("R10 read zero hi", {16'h0, d}, 32'h0);
        chk_reg("R10 out kept", 12'h00C, m_out);
        chk_reg("R10 oe kept", 12'h008, m_oe);

        // R11 input write ignored
        wr(12'h010, 16'h0000);
        wr(12'h510, 16'h0000);
        chk_reg("R11 in write ignored", 12'h010, 32'hFFFF_FFFF);

        // R3 rising, latency three edges
        wr(12'h018, 16'h0001); m_rise[15:0] = 16'h0001;
        pin_in = 32'hFFFF_FFFE; m_in = pin_in;
        repeat (3) @(negedge clk);
        check("R5 fall unarmed", {31'h0, irq}, 32'h0);
        pin_in = 32'hFFFF_FFFF;
        repeat (2) @(negedge clk);
        check("R3 not before third edge", {31'h0, irq}, 32'h0);
        @(negedge clk);
        m_in = pin_in; m_stat[0] = 1'b1;
        check("R3 irq", {31'h0, irq}, 32'h1);
        chk_reg("R3 stat", 12'h020, m_stat);
        chk_reg("R11 in level", 12'h010, m_in);

        // R6 write zero keeps, write one clears
        wr(12'h020, 16'h0000);
        check("R6 zero keeps", {31'h0, irq}, 32'h1);
        clr_stat(32'h0000_0001);
        check("R6 clear", {31'h0, irq}, 32'h0);

        // R4 falling on an upper pin
        wr(12'h514, 16'h8000); m_fall[31:16] = 16'h8000;
        apply_pins(32'h7FFF_FFFF);
        chk_reg("R4 stat", 12'h020, m_stat);
        check("R4 irq", {31'h0, irq}, 32'h1);

        // R7 clear and event in the same cycle: bit 0 rises, clear covers bits 0 and 31
        pin_in = 32'h7FFF_FFFE; m_in = pin_in;
        repeat (3) @(negedge clk);
        pin_in = 32'h7FFF_FFFF;
        @(negedge clk);
        @(negedge clk);
        bus_addr = 12'h020; bus_wdata = 16'h0001; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_addr = 12'h520; bus_wdata = 16'h8000; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        m_in = pin_in; m_stat = 32'h0000_0001;
        chk_reg("R7 set wins", 12'h020, m_stat);
        clr_stat(32'hFFFF_FFFF);

        // R2 random half writes
        for (int i = 0; i < 60; i++) begin
            int sel;
            bit up;
            logic [15:0] v;
            logic [11:0] a;
            sel = $urandom % 4;
            up = $urandom % 2;
            v = $urandom;
            a = base_of(sel) + (up ? 12'h500 : 12'h0);
            wr(a, v);
            case (sel)
                0: if (up) m_oe[31:16] = v; else m_oe[15:0] = v;
                1: if (up) m_out[31:16] = v; else m_out[15:0] = v;
                2: if (up) m_fall[31:16] = v; else m_fall[15:0] = v;
                default: if (up) m_rise[31:16] = v; else m_rise[15:0] = v;
            endcase
            chk_reg("R2 random oe", 12'h008, m_oe);
            chk_reg("R2 random out", 12'h00C, m_out);
            chk_reg("R2 random fall", 12'h014, m_fall);
            chk_reg("R2 random rise", 12'h018, m_rise);
            chk_side("R9 R8 random side");
        end

        // R3 R4 R5 R6 random pins against random masks
        for (int i = 0; i < 80; i++) begin
            apply_pins($urandom);
            chk_reg("R3 R4 R5 random stat", 12'h020, m_stat);
            chk_reg("R11 random in", 12'h010, m_in);
            check("R6 random irq", {31'h0, irq}, {31'h0, |m_stat});
            if (i % 3 == 0) begin
                clr_stat($urandom);
                chk_reg("R6 random clear", 12'h020, m_stat);
            end
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule